// File: doc/BRIEF.md
# Alarm Time Match With Latched Ring

This block holds a four-digit alarm time and watches the running four-digit time of day for it. A pulse on `set_i` loads the digits on `alarm_digits_i` into internal storage and arms the alarm. Once armed, the block compares the stored time against `now_digits_i` on every clock. When all digits agree, the block raises `ring_o` and keeps it high until `dismiss_i` clears it.

The alarm can be reloaded at any moment by pulsing `set_i` again with new digits. No input disarms a stored alarm. The ring fires only on entry into the matching time. If the alarm is dismissed while the clock still shows the matching minute, it does not ring again. Every action happens on the rising edge of `clk`, and `rst_n` is an asynchronous active-low reset.

Digits are packed four bits each. Digit 0, the least significant (units of minutes), is in bits [3:0]. Digit 3 (tens of hours) is in bits [15:12]. All pins are plain level-sampled control and data pins with no handshake, because the time of day is a continuously valid value rather than a stream.

Top module: `alarm_match`

## Requirements
- R1: After reset, `ring_o` is 0 and no alarm is armed. A current time equal to the reset storage contents (00:00) does not ring before the first `set_i`.
- R2: A rising edge with `set_i` = 1 captures all four digits of `alarm_digits_i` and arms the alarm.
- R3: A later `set_i` replaces the stored time completely. The previously stored time no longer rings.
- R4: `ring_o` rises at the edge that ends the first cycle in which all four digits of `now_digits_i` equal the stored digits. A match on only three digits does not ring.
- R5: Once high, `ring_o` stays high across any change of time until an edge with `dismiss_i` = 1. It is 0 after that edge.
- R6: The ring fires only on a transition from not-matching to matching. While the matching time is held after a dismiss, `ring_o` stays 0. Leaving that time and returning to it fires the ring again.
- R7: When `dismiss_i` = 1 in the same cycle as a new match, dismiss wins and `ring_o` stays 0.
- R8: Asserting `set_i` while ringing does not clear `ring_o`. There is no cancel path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 1 | Capture alarm digits and arm |
| dismiss_i | input | 1 | Clear the ring |
| alarm_digits_i | input | 16 | Alarm time, four BCD digits, digit 0 in [3:0] |
| now_digits_i | input | 16 | Current time, four BCD digits, digit 0 in [3:0] |
| ring_o | output | 1 | Latched alarm indication |

## Verification
The bench attacks the cleared-storage case: reset contents equal 00:00, so a design that forgot the armed bit would ring at midnight before any alarm is set. It holds the matching time after a dismiss to catch a level-sensitive comparator that re-rings at once. It collides dismiss with a fresh match to catch a priority that lets the match win. It reloads the alarm to show that the old time is forgotten and that a reload neither cancels nor restarts a ring. Partial matches, a full-day sweep through the wrap from 23:59 to 00:00, and a per-cycle behavioural model catch a comparator that ignores one digit or a ring that drops early.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DEF_NUM_DIGITS = 4;
  localparam int DEF_DIGIT_W    = 4;

  // Extract one digit from a packed vector of digits.
  function automatic logic [DEF_DIGIT_W-1:0] digit_at(
    input logic [DEF_NUM_DIGITS*DEF_DIGIT_W-1:0] vec,
    input int unsigned                          idx
  );
    return vec[idx*DEF_DIGIT_W +: DEF_DIGIT_W];
  endfunction
endpackage

// File: rtl/alarm_store.sv
module alarm_store #(
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_W    = 4,
  localparam int VEC_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [VEC_W-1:0] digits_i,
  output logic [VEC_W-1:0] stored_o,
  output logic             armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_o <= '0;
      armed_o  <= 1'b0;
    end else if (set_i) begin
      stored_o <= digits_i;
      armed_o  <= 1'b1;
    end
  end

  // R2: capture of the applied digits and arming
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (armed_o && stored_o == $past(digits_i)));

  // R3: storage only changes on a set
  a_r3_hold_store: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> $stable(stored_o));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare #(
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_W    = 4,
  localparam int VEC_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic [VEC_W-1:0] stored_i,
  input  logic [VEC_W-1:0] now_i,
  output logic             match_o,
  output logic             hit_o
);
  logic [NUM_DIGITS-1:0] digit_eq;
  logic                  match_q;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign digit_eq[g] = (stored_i[g*DIGIT_W +: DIGIT_W] == now_i[g*DIGIT_W +: DIGIT_W]);
  end

  assign match_o = armed_i && (&digit_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_o;
  end

  // Entry into the matching time only
  assign hit_o = match_o && !match_q;

  // R6: no two hits in consecutive cycles
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

  // R1: nothing matches while unarmed
  a_r1_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |-> !match_o);
endmodule

// File: rtl/alarm_ring.sv
module alarm_ring (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic dismiss_i,
  output logic ring_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ring_o <= 1'b0;
    else if (dismiss_i) ring_o <= 1'b0;
    else if (hit_i)     ring_o <= 1'b1;
  end

  // R5 / R7: dismiss always clears, even against a hit
  a_r5_dismiss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dismiss_i |=> !ring_o);

  // R5: ring held without dismiss
  a_r5_ring_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_o && !dismiss_i) |=> ring_o);
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NUM_DIGITS = alarm_pkg::DEF_NUM_DIGITS,
  parameter int DIGIT_W    = alarm_pkg::DEF_DIGIT_W,
  localparam int VEC_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             dismiss_i,
  input  logic [VEC_W-1:0] alarm_digits_i,
  input  logic [VEC_W-1:0] now_digits_i,
  output logic             ring_o
);
  logic [VEC_W-1:0] stored;
  logic             armed;
  logic             match;
  logic             hit;

  alarm_store #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_i),
    .digits_i (alarm_digits_i),
    .stored_o (stored),
    .armed_o  (armed)
  );

  alarm_compare #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_compare (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed_i  (armed),
    .stored_i (stored),
    .now_i    (now_digits_i),
    .match_o  (match),
    .hit_o    (hit)
  );

  alarm_ring u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .dismiss_i (dismiss_i),
    .ring_o    (ring_o)
  );

  // R4: a ring only starts after a matching, undismissed cycle
  a_r4_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_o) |-> ($past(match) && !$past(dismiss_i)));

  // R1: no ring without an armed alarm
  a_r1_ring_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ring_o |-> armed);
endmodule

// File: tb/alarm_match_bench.sv
module alarm_match_bench;
  localparam int W = 16;

  logic         clk = 1'b0, rst_n = 1'b0, set = 1'b0, dismiss = 1'b0;
  logic [W-1:0] alarm_d = '0, now_d = '0;
  logic         ring;
  int           checks = 0, errors = 0, cycles = 0;
  string        tag = "R1";

  always #10 clk = ~clk;

  alarm_match u_alarm_match (
    .clk(clk), .rst_n(rst_n), .set_i(set), .dismiss_i(dismiss),
    .alarm_digits_i(alarm_d), .now_digits_i(now_d), .ring_o(ring)
  );

  // Behavioural reference model
  bit           m_armed = 0, m_prev = 0, m_ring = 0;
  logic [W-1:0] m_alarm = '0;
  always @(posedge clk) begin
    bit mt;
    if (!rst_n) begin
      m_armed = 0; m_prev = 0; m_ring = 0; m_alarm = '0;
    end else begin
      mt = m_armed && (now_d == m_alarm);
      if (dismiss) m_ring = 0;
      else if (mt && !m_prev) m_ring = 1;
      m_prev = mt;
      if (set) begin m_alarm = alarm_d; m_armed = 1; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (ring !== m_ring) begin
        errors++;
        $display("FAIL %s model: ring=%0b expected=%0b at cycle %0d", tag, ring, m_ring, cycles);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] hm(input int h, input int m);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10)};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit exp, input string t);
    checks++;
    if (ring !== exp) begin
      errors++;
      $display("FAIL %s: ring=%0b expected=%0b", t, ring, exp);
    end
  endtask

  initial begin
    // R1: reset and unarmed midnight
    step(); step();
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    now_d = hm(0, 0);
    step(); step(); step();
    chk(1'b0, "R1 unarmed at 00:00");

    // R2 / R4: capture and partial matches
    tag = "R4";
    alarm_d = hm(7, 30); set = 1'b1; step(); set = 1'b0;
    alarm_d = hm(5, 5);
    now_d = hm(7, 29); step(); chk(1'b0, "R4 before match");
    now_d = hm(17, 30); step(); chk(1'b0, "R4 digit3 differs");
    now_d = hm(7, 20); step(); chk(1'b0, "R4 digit1 differs");
    now_d = hm(7, 31); step(); chk(1'b0, "R4 digit0 differs");
    now_d = hm(7, 30); step(); chk(1'b1, "R2 R4 ring on full match");

    // R5: sticky until dismiss
    tag = "R5";
    now_d = hm(7, 31); step(); step(); step();
    chk(1'b1, "R5 held after time moves");
    dismiss = 1'b1; step(); dismiss = 1'b0;
    chk(1'b0, "R5 cleared by dismiss");
    step(); chk(1'b0, "R5 stays clear");

    // R6: no re-ring inside the same matching window
    tag = "R6";
    alarm_d = hm(8, 0); set = 1'b1; now_d = hm(8, 0); step(); set = 1'b0;
    step(); chk(1'b1, "R6 ring at 08:00");
    dismiss = 1'b1; step(); dismiss = 1'b0;
    step(); step(); step();
    chk(1'b0, "R6 no re-ring while still 08:00");
    now_d = hm(8, 1); step();
    now_d = hm(8, 0); step();
    chk(1'b1, "R6 re-entry rings again");
    dismiss = 1'b1; step(); dismiss = 1'b0;

    // R3: overwrite
    tag = "R3";
    now_d = hm(8, 30);
    alarm_d = hm(9, 0);  set = 1'b1; step();
    alarm_d = hm(10, 15); step(); set = 1'b0;
    for (int i = 0; i < 3; i++) begin now_d = hm(9, i); step(); end
    chk(1'b0, "R3 old alarm forgotten");
    now_d = hm(10, 15); step();
    chk(1'b1, "R3 new alarm rings");
    dismiss = 1'b1; step(); dismiss = 1'b0;

    // R7: dismiss beats a simultaneous match
    tag = "R7";
    now_d = hm(10, 14); step();
    now_d = hm(10, 15); dismiss = 1'b1; step(); dismiss = 1'b0;
    chk(1'b0, "R7 dismiss wins over match");
    step(); chk(1'b0, "R7 no late ring in same minute");

    // R8: set while ringing does not cancel
    tag = "R8";
    now_d = hm(10, 16); step();
    now_d = hm(10, 15); step(); chk(1'b1, "R8 ringing");
    alarm_d = hm(11, 0); set = 1'b1; step(); set = 1'b0;
    chk(1'b1, "R8 set keeps ring");
    step(); chk(1'b1, "R8 still ringing");
    dismiss = 1'b1; step(); dismiss = 1'b0;
    chk(1'b0, "R8 dismiss after set");

    // R4: full-day sweep with wrap
    tag = "R4";
    alarm_d = hm(23, 59); set = 1'b1; step(); set = 1'b0;
    for (int m = 0; m < 1440; m++) begin
      now_d = hm(m / 60, m % 60); step();
    end
    chk(1'b1, "R4 ring at 23:59");
    now_d = hm(0, 0); step();
    chk(1'b1, "R4 held across wrap");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule